// File: doc/BRIEF.md
# Flash Page Write Sequencer

This block runs flash row programming on a synchronous flash array model that is held inside the block. Two requesters share one small command register set: a debug port and a CPU bus port. A requester writes an opcode, a row index, a word index and a data byte into input registers. It then writes the execute register. Nothing starts until that execute write arrives.

Some commands finish in the cycle after the execute write: loading one word into the page latch, reading one word, and summing a row. The other two commands run for a number of cycles and hold `busy` high: erasing a row, and writing a row from the latch. A row write passes through three timed phases. First every bit of the row is driven to one. Then the row is erased to zero. Finally only the bits that are set in the latch are programmed.

The outcome is kept in a status register. A command can be issued in non-blocking mode. In that mode a long command raises `irq` when it completes, and the flag stays up until a requester writes the acknowledge register.

Top module: `flash_page_seq`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `busy`=0, `status`=0 (idle), `phase`=0, `irq`=0 and `result`=0. The flash array and the page latch both reset to all zeros.
- R2: The register addresses are 0 opcode, 1 row, 2 word index, 3 data, 4 execute and 5 acknowledge. In the opcode register, bits [2:0] select the operation and bit 7 selects non-blocking mode. Writing addresses 0 to 3 changes no output. An operation starts only on a write to address 4.
- R3: Opcode 1 loads the data register into the page latch word given by the word index. The status becomes 2 (pass) in the cycle after the execute write.
- R4: Opcode 2 writes the latch to a row in three phases, each lasting PHASE_CYC cycles: `phase` 1 drives the whole row to ones, `phase` 2 clears it, and `phase` 3 ORs in the latch. Afterwards the row equals the latch, whatever the row held before.
- R5: Opcode 3 erases a row to zero in a single phase (`phase`=2) that lasts PHASE_CYC cycles.
- R6: From the cycle after the execute write of opcode 2 or 3 until the command completes, `busy`=1 and `status` is 1 (busy) or 4. At completion `busy` falls and `status`=2 in the same cycle.
- R7: A non-blocking opcode 2 or 3 sets `irq` when it completes. A write to address 5 clears `irq`. A blocking command never sets `irq`.
- R8: If both ports write in the same cycle, the debug port's write takes effect and the CPU port's write is dropped.
- R9: While `busy`=1, an execute write sets `status` to 4 (refused) and writes to addresses 0 to 3 are ignored. The running command still completes normally.
- R10: The command finishes in the next cycle with `status`=3 (fail), and leaves `result` and the flash unchanged, in any of these cases: opcodes 0, 6 or 7; a row index of ROWS or more for opcodes 2 to 5; a word index of WORDS or more for opcodes 1 and 5.
- R11: Opcode 4 puts the sum of all words of the row into `result`, with status 2.
- R12: Opcode 5 puts the addressed flash word, zero-extended, into `result`, with status 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_wr | input | 1 | Debug port register write strobe |
| dbg_addr | input | 3 | Debug port register address |
| dbg_wdata | input | DW | Debug port write data |
| cpu_wr | input | 1 | CPU port register write strobe |
| cpu_addr | input | 3 | CPU port register address |
| cpu_wdata | input | DW | CPU port write data |
| busy | output | 1 | A long command is running |
| status | output | 3 | 0 idle, 1 busy, 2 pass, 3 fail, 4 refused |
| phase | output | 2 | 0 none, 1 set all, 2 clear, 3 program selected |
| irq | output | 1 | Non-blocking completion flag |
| result | output | DW+log2(WORDS) | Read word or row sum |

## Verification
The bench builds the block with ROWS=8, WORDS=4, DW=8 and PHASE_CYC=3. Three-cycle phases keep each row write short, so the bench can cover several writes, a refused request in the middle of a write, and every phase boundary within a few hundred cycles. With eight rows, row index 8 is the first value out of range. With four words of eight bits, a row sum exceeds eight bits and exercises the wider result.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_BUSY    = 3'd1,
    ST_PASS    = 3'd2,
    ST_FAIL    = 3'd3,
    ST_REFUSED = 3'd4
  } fsq_status_e;

  typedef enum logic [1:0] {
    PH_NONE    = 2'd0,
    PH_SETALL  = 2'd1,
    PH_CLEAR   = 2'd2,
    PH_PROGSEL = 2'd3
  } fsq_phase_e;

  localparam logic [2:0] OP_LOAD  = 3'd1;
  localparam logic [2:0] OP_WRITE = 3'd2;
  localparam logic [2:0] OP_ERASE = 3'd3;
  localparam logic [2:0] OP_SUM   = 3'd4;
  localparam logic [2:0] OP_READ  = 3'd5;

  localparam logic [2:0] A_OPC  = 3'd0;
  localparam logic [2:0] A_ROW  = 3'd1;
  localparam logic [2:0] A_COL  = 3'd2;
  localparam logic [2:0] A_DATA = 3'd3;
  localparam logic [2:0] A_EXEC = 3'd4;
  localparam logic [2:0] A_ACK  = 3'd5;
endpackage

// File: rtl/fsq_arbiter.sv
// Fixed-priority merge of the two requester ports: debug wins.
module fsq_arbiter #(
  parameter int DW = 8
) (
  input  logic          dbg_wr,
  input  logic [2:0]    dbg_addr,
  input  logic [DW-1:0] dbg_wdata,
  input  logic          cpu_wr,
  input  logic [2:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          g_wr,
  output logic [2:0]    g_addr,
  output logic [DW-1:0] g_data
);
  always_comb begin
    g_wr   = dbg_wr | cpu_wr;
    g_addr = dbg_wr ? dbg_addr  : cpu_addr;
    g_data = dbg_wr ? dbg_wdata : cpu_wdata;
  end
endmodule

// File: rtl/fsq_page_latch.sv
// Row-wide staging buffer, written one word at a time.
module fsq_page_latch #(
  parameter int WORDS = 4,
  parameter int DW    = 8,
  localparam int CAW  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [CAW-1:0]      idx,
  input  logic [DW-1:0]       wdata,
  output logic [WORDS*DW-1:0] row
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            word_q <= '0;
      else if (we && (idx == CAW'(w)))       word_q <= wdata;
    end
    assign row[w*DW +: DW] = word_q;
  end
endmodule

// File: rtl/fsq_flash_array.sv
// Synchronous flash array model: whole-row set, clear and program-OR.
module fsq_flash_array
  import fsq_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int WORDS = 4,
  parameter int DW    = 8,
  localparam int RAW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int LW   = WORDS * DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_en,
  input  fsq_phase_e     op_kind,
  input  logic [RAW-1:0] row_idx,
  input  logic [LW-1:0]  op_data,
  output logic [LW-1:0]  rd_row
);
  logic [LW-1:0] cells [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cells[r] <= '0;
      end else if (op_en && (row_idx == RAW'(r))) begin
        case (op_kind)
          PH_SETALL:  cells[r] <= '1;
          PH_CLEAR:   cells[r] <= '0;
          PH_PROGSEL: cells[r] <= cells[r] | op_data;
          default:    cells[r] <= cells[r];
        endcase
      end
    end
  end

  assign rd_row = cells[row_idx];
endmodule

// File: rtl/flash_page_seq.sv
module flash_page_seq
  import fsq_pkg::*;
#(
  parameter int ROWS      = 8,
  parameter int WORDS     = 4,
  parameter int DW        = 8,
  parameter int PHASE_CYC = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        dbg_wr,
  input  logic [2:0]                  dbg_addr,
  input  logic [DW-1:0]               dbg_wdata,
  input  logic                        cpu_wr,
  input  logic [2:0]                  cpu_addr,
  input  logic [DW-1:0]               cpu_wdata,
  output logic                        busy,
  output logic [2:0]                  status,
  output logic [1:0]                  phase,
  output logic                        irq,
  output logic [DW+$clog2(WORDS)-1:0] result
);
  localparam int RAW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CAW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int CW  = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam int RW  = DW + $clog2(WORDS);
  localparam int LW  = WORDS * DW;

  logic          g_wr;
  logic [2:0]    g_addr;
  logic [DW-1:0] g_data;

  logic [DW-1:0] opc_q, row_q, col_q, dat_q, opc_d, row_d, col_d, dat_d;
  fsq_phase_e    ph_q, ph_d;
  fsq_status_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_q, wr_d, nb_q, nb_d, irq_q, irq_d;
  logic [RW-1:0] res_q, res_d;

  logic [LW-1:0] latch_row, arr_row;
  logic [RW-1:0] row_sum;
  logic [DW-1:0] rd_word;
  logic          busy_w, exec_w, phase_end, row_ok, col_ok, latch_we;

  fsq_arbiter #(.DW(DW)) u_arb (
    .dbg_wr(dbg_wr), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .g_wr(g_wr), .g_addr(g_addr), .g_data(g_data)
  );

  fsq_page_latch #(.WORDS(WORDS), .DW(DW)) u_latch (
    .clk(clk), .rst_n(rst_n), .we(latch_we), .idx(col_q[CAW-1:0]),
    .wdata(dat_q), .row(latch_row)
  );

  fsq_flash_array #(.ROWS(ROWS), .WORDS(WORDS), .DW(DW)) u_array (
    .clk(clk), .rst_n(rst_n), .op_en(phase_end), .op_kind(ph_q),
    .row_idx(row_q[RAW-1:0]), .op_data(latch_row), .rd_row(arr_row)
  );

  assign busy_w    = (ph_q != PH_NONE);
  assign exec_w    = g_wr && (g_addr == A_EXEC);
  assign phase_end = busy_w && (cnt_q == '0);
  assign row_ok    = (int'(row_q) < ROWS);
  assign col_ok    = (int'(col_q) < WORDS);
  assign latch_we  = exec_w && !busy_w && (opc_q[2:0] == OP_LOAD) && col_ok;
  assign rd_word   = arr_row[DW*int'(col_q[CAW-1:0]) +: DW];

  always_comb begin
    row_sum = '0;
    for (int w = 0; w < WORDS; w++) row_sum = row_sum + RW'(arr_row[w*DW +: DW]);
  end

  // next-state logic
  always_comb begin
    opc_d = opc_q; row_d = row_q; col_d = col_q; dat_d = dat_q;
    ph_d  = ph_q;  st_d  = st_q;  cnt_d = cnt_q;
    wr_d  = wr_q;  nb_d  = nb_q;  irq_d = irq_q; res_d = res_q;

    if (g_wr && (g_addr == A_ACK)) irq_d = 1'b0;

    if (g_wr && !busy_w) begin
      case (g_addr)
        A_OPC:   opc_d = g_data;
        A_ROW:   row_d = g_data;
        A_COL:   col_d = g_data;
        A_DATA:  dat_d = g_data;
        default: ;
      endcase
    end

    if (busy_w) begin
      if (exec_w) st_d = ST_REFUSED;
      if (phase_end) begin
        cnt_d = CW'(PHASE_CYC - 1);
        case (ph_q)
          PH_SETALL: ph_d = PH_CLEAR;
          PH_CLEAR:  ph_d = wr_q ? PH_PROGSEL : PH_NONE;
          default:   ph_d = PH_NONE;
        endcase
        if (ph_d == PH_NONE) begin
          st_d = ST_PASS;
          if (nb_q) irq_d = 1'b1;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (exec_w) begin
      st_d  = ST_FAIL;
      nb_d  = opc_q[7];
      cnt_d = CW'(PHASE_CYC - 1);
      case (opc_q[2:0])
        OP_LOAD:  if (col_ok) st_d = ST_PASS;
        OP_WRITE: if (row_ok) begin ph_d = PH_SETALL; wr_d = 1'b1; st_d = ST_BUSY; end
        OP_ERASE: if (row_ok) begin ph_d = PH_CLEAR;  wr_d = 1'b0; st_d = ST_BUSY; end
        OP_SUM:   if (row_ok) begin res_d = row_sum; st_d = ST_PASS; end
        OP_READ:  if (row_ok && col_ok) begin res_d = RW'(rd_word); st_d = ST_PASS; end
        default:  ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q <= '0; row_q <= '0; col_q <= '0; dat_q <= '0;
      ph_q  <= PH_NONE; st_q <= ST_IDLE; cnt_q <= '0;
      wr_q  <= 1'b0; nb_q <= 1'b0; irq_q <= 1'b0; res_q <= '0;
    end else begin
      opc_q <= opc_d; row_q <= row_d; col_q <= col_d; dat_q <= dat_d;
      ph_q  <= ph_d;  st_q  <= st_d;  cnt_q <= cnt_d;
      wr_q  <= wr_d;  nb_q  <= nb_d;  irq_q <= irq_d; res_q <= res_d;
    end
  end

  assign busy   = busy_w;
  assign status = st_q;
  assign phase  = ph_q;
  assign irq    = irq_q;
  assign result = res_q;
endmodule

// File: rtl/fsq_checker.sv
module fsq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic [2:0] status,
  input logic [1:0] phase,
  input logic       irq
);
  AST_START_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (phase == 2'd1 || phase == 2'd2));                       // R4
  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == 2'd1 && phase != 2'd1) |-> (phase == 2'd2));            // R4
  AST_ERASE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == 2'd3 && phase != 2'd3) |-> (phase == 2'd0));            // R4
  AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (status == 3'd1 || status == 3'd4));                            // R6
  AST_DONE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (status == 3'd2));                                       // R6
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(busy));                                             // R7
endmodule

bind flash_page_seq fsq_checker u_fsq_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .status(status),
  .phase(phase), .irq(irq)
);

// File: tb/tb_flash_page_seq.sv
`timescale 1ns/1ps
module tb_flash_page_seq;
  localparam int ROWS = 8, WORDS = 4, DW = 8, PC = 3;
  localparam int RW = DW + $clog2(WORDS);

  logic          clk, rst_n;
  logic          dbg_wr, cpu_wr;
  logic [2:0]    dbg_addr, cpu_addr;
  logic [DW-1:0] dbg_wdata, cpu_wdata;
  logic          busy, irq;
  logic [2:0]    status;
  logic [1:0]    phase;
  logic [RW-1:0] result;

  flash_page_seq #(.ROWS(ROWS), .WORDS(WORDS), .DW(DW), .PHASE_CYC(PC)) dut (
    .clk(clk), .rst_n(rst_n),
    .dbg_wr(dbg_wr), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .busy(busy), .status(status), .phase(phase), .irq(irq), .result(result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit live = 0, done = 0;
  string cur_req = "R1";

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_mem[ROWS][WORDS];
  int m_lat[WORDS];
  int m_opc, m_row, m_col, m_dat, m_ph, m_cnt, m_st, m_irq, m_res, m_wr, m_nb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[r, w]) m_mem[r][w] = 0;
      foreach (m_lat[w]) m_lat[w] = 0;
      m_opc = 0; m_row = 0; m_col = 0; m_dat = 0; m_ph = 0; m_cnt = 0;
      m_st = 0; m_irq = 0; m_res = 0; m_wr = 0; m_nb = 0;
    end else begin
      int gw, ga, gd, bsy, op, s;
      gw = dbg_wr || cpu_wr;
      ga = dbg_wr ? dbg_addr : cpu_addr;
      gd = dbg_wr ? dbg_wdata : cpu_wdata;
      bsy = (m_ph != 0);
      if (gw && ga == 5) m_irq = 0;
      if (gw && !bsy) begin
        if (ga == 0) m_opc = gd;
        if (ga == 1) m_row = gd;
        if (ga == 2) m_col = gd;
        if (ga == 3) m_dat = gd;
      end
      if (bsy) begin
        if (gw && ga == 4) m_st = 4;
        if (m_cnt == 0) begin
          for (int w = 0; w < WORDS; w++) begin
            if (m_ph == 1) m_mem[m_row][w] = 255;
            else if (m_ph == 2) m_mem[m_row][w] = 0;
            else m_mem[m_row][w] = m_mem[m_row][w] | m_lat[w];
          end
          m_ph = (m_ph == 1) ? 2 : ((m_ph == 2 && m_wr) ? 3 : 0);
          m_cnt = PC - 1;
          if (m_ph == 0) begin m_st = 2; if (m_nb) m_irq = 1; end
        end else m_cnt--;
      end else if (gw && ga == 4) begin
        op = m_opc % 8; m_nb = m_opc / 128; m_cnt = PC - 1; m_st = 3;
        if (op == 1 && m_col < WORDS) begin m_lat[m_col] = m_dat; m_st = 2; end
        if (op == 2 && m_row < ROWS) begin m_ph = 1; m_wr = 1; m_st = 1; end
        if (op == 3 && m_row < ROWS) begin m_ph = 2; m_wr = 0; m_st = 1; end
        if (op == 4 && m_row < ROWS) begin
          s = 0; for (int w = 0; w < WORDS; w++) s += m_mem[m_row][w];
          m_res = s; m_st = 2;
        end
        if (op == 5 && m_row < ROWS && m_col < WORDS) begin
          m_res = m_mem[m_row][m_col]; m_st = 2;
        end
      end
    end
  end

  always @(negedge clk) if (live && !done) begin
    chk(cur_req, "busy",   busy,   m_ph != 0);
    chk(cur_req, "status", status, m_st);
    chk(cur_req, "phase",  phase,  m_ph);
    chk(cur_req, "irq",    irq,    m_irq);
    chk(cur_req, "result", result, m_res);
  end

  task automatic wr(int p, int a, int d);
    if (p == 0) begin dbg_wr = 1; dbg_addr = 3'(a); dbg_wdata = 8'(d); end
    else        begin cpu_wr = 1; cpu_addr = 3'(a); cpu_wdata = 8'(d); end
    @(negedge clk);
    dbg_wr = 0; cpu_wr = 0;
  endtask

  task automatic op(int p, int opc, int row, int col, int dat);
    wr(p, 0, opc); wr(p, 1, row); wr(p, 2, col); wr(p, 3, dat); wr(p, 4, 0);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("WD", "watchdog", 1, 0);
    finish_run();
  end

  initial begin
    dbg_wr = 0; cpu_wr = 0; dbg_addr = 0; cpu_addr = 0; dbg_wdata = 0; cpu_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1", "status in reset", status, 0);
    chk("R1", "busy in reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    live = 1;
    chk("R1", "result after reset", result, 0);
    chk("R1", "irq after reset", irq, 0);

    cur_req = "R2";
    wr(0, 0, 1); wr(0, 2, 1); wr(0, 3, 8'hA5);
    chk("R2", "no action before execute", status, 0);
    cur_req = "R3";
    wr(0, 4, 0);
    chk("R3", "load pass", status, 2);
    op(0, 1, 0, 0, 8'h11); op(1, 1, 0, 1, 8'h22);
    op(0, 1, 0, 2, 8'h44); op(1, 1, 0, 3, 8'h80);

    cur_req = "R4";
    op(0, 2, 2, 0, 0);
    chk("R4", "phase set-all first", phase, 1);
    chk("R6", "busy after execute", busy, 1);
    repeat (PC) @(negedge clk);
    chk("R4", "phase clear second", phase, 2);
    repeat (PC) @(negedge clk);
    chk("R4", "phase program third", phase, 3);
    repeat (PC) @(negedge clk);
    chk("R6", "done status", status, 2);
    chk("R6", "busy released", busy, 0);
    chk("R7", "blocking leaves irq low", irq, 0);
    cur_req = "R12";
    op(0, 5, 2, 2, 0);
    chk("R12", "read word", result, 8'h44);
    cur_req = "R11";
    op(1, 4, 2, 0, 0);
    chk("R11", "row sum", result, 247);

    cur_req = "R7";
    op(0, 1, 0, 0, 8'h0F);
    op(0, 8'h82, 2, 0, 0);
    wait_idle();
    chk("R7", "irq on nb completion", irq, 1);
    op(0, 5, 2, 0, 0);
    chk("R4", "row replaced not merged", result, 8'h0F);
    wr(1, 5, 0);
    chk("R7", "irq cleared by ack", irq, 0);

    cur_req = "R9";
    op(0, 2, 2, 0, 0);
    wr(1, 4, 0);
    chk("R9", "refused while busy", status, 4);
    wr(1, 1, 5);
    wait_idle();
    chk("R9", "running op completes", status, 2);
    wr(0, 0, 5); wr(0, 4, 0);
    chk("R9", "row register kept", result, 8'h0F);

    cur_req = "R8";
    dbg_wr = 1; dbg_addr = 1; dbg_wdata = 2;
    cpu_wr = 1; cpu_addr = 1; cpu_wdata = 9;
    @(negedge clk);
    dbg_wr = 0; cpu_wr = 0;
    wr(0, 0, 4); wr(0, 4, 0);
    chk("R8", "debug write wins", status, 2);
    chk("R8", "sum of debug row", result, 245);

    cur_req = "R5";
    op(1, 3, 2, 0, 0);
    chk("R5", "erase single phase", phase, 2);
    repeat (PC) @(negedge clk);
    chk("R5", "erase finished", busy, 0);
    op(1, 4, 2, 0, 0);
    chk("R5", "erased row sum", result, 0);

    cur_req = "R10";
    op(0, 3, 6, 0, 0); wait_idle();
    op(0, 5, 1, 1, 0);
    op(0, 0, 1, 0, 0);
    chk("R10", "opcode 0 fails", status, 3);
    op(0, 7, 1, 0, 0);
    chk("R10", "opcode 7 fails", status, 3);
    op(0, 2, 8, 0, 0);
    chk("R10", "row out of range fails", status, 3);
    chk("R10", "no busy on bad row", busy, 0);
    op(0, 5, 1, 4, 0);
    chk("R10", "word out of range fails", status, 3);
    op(0, 1, 0, 4, 8'h77);
    chk("R10", "load bad word fails", status, 3);
    chk("R10", "result unchanged", result, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule